// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog for a processor subsystem, reached through a small word-indexed register port. Software programs a timeout, an enable, a freeze option, an expiry action and an optional clock prescaler into a control word. Then it keeps the down-counter from running out by writing a two-word key into a service register. If the counter runs out, the block pulses either a reset request or an interrupt. A reset-causing expiry leaves a sticky status flag that software clears by writing a one.

The control word can be accepted only once after power-on reset, so a running watchdog cannot be stopped by a stray or hostile write. In the same way, a watchdog left off stays off. Reading the control word back shows what was actually latched.

Three small state machines hold the state. The control lock moves from CTL_OPEN to CTL_SEALED on the first control write and never leaves CTL_SEALED. The key sequencer moves from KEY_IDLE to KEY_ARMED on the arm key. It returns from KEY_ARMED to KEY_IDLE on the next service write: that write fires a reload if it is the second key, and only disarms otherwise. The counter sequencer chooses CNT_OFF when counting is disabled, CNT_HALT when freeze is set and debug halt is high, and CNT_RUN otherwise. It re-evaluates every clock.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control word reads 0, the count reads 65536 (0x10000), status reads 0, and both expiry outputs are low.
- R2: The first control write (word index 0) latches bits 31:16 as timeout, bit 3 freeze, bit 2 enable, bit 1 action select and bit 0 prescale enable, and reads back with all other bits 0. Every later control write is ignored.
- R3: If the first control write leaves enable (bit 2) at 0, the count stays constant, and a later control write with enable set has no effect.
- R4: An accepted control write loads the count (word index 1, bits 16:0) with the new timeout at that same clock edge. With prescale off, a running count then falls by one every clock.
- R5: With prescale on, the count falls by one every PRESC_RATIO clocks. The first decrement comes PRESC_RATIO clocks after the load.
- R6: A service write (word index 2, bits 15:0) of 0x556C followed by a service write of 0xAA39 reloads the count with the timeout. 0xAA39 without a preceding 0x556C, or any value other than 0xAA39 after 0x556C, does not reload, and that second write disarms the sequence.
- R7: Expiry happens on the decrement from 1. The clock after that decrement, exactly one of wdt_rst_req (action select 1) or wdt_irq (action select 0) is high, for one cycle.
- R8: On expiry the count reloads with the timeout in the same clock, so the period is timeout clocks (without prescale).
- R9: A timeout field of 0 loads a count of 65536.
- R10: With freeze set, raising dbg_halt pauses counting from one clock later, and lowering it resumes counting one clock later. Without freeze, dbg_halt has no effect.
- R11: Status bit 0 (word index 3) goes to 1 the clock after a wdt_rst_req pulse and stays set. Writing 1 to it clears it and writing 0 does not. An interrupt-mode expiry does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr | input | 1 | Register write strobe, one word per clock |
| reg_addr | input | ADDR_W (2) | Word index: 0 control, 1 count, 2 service, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| dbg_halt | input | 1 | Debug halt; pauses counting when freeze is set |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |
| wdt_irq | output | 1 | One-cycle interrupt on expiry |

## Verification
Each result is due in a particular cycle. A control or service write shows in the count read in the cycle right after its clock edge. A decrement from 1 gives the expiry pulse one cycle after that edge. The status flag follows the reset pulse by one further clock. A dbg_halt change takes effect one clock late. The bench drives inputs and samples the combinational read port on falling edges, and counts the rising edges between a stimulus and its check. For key sequences it reads the count just before the second key and expects either the timeout or that value minus one.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int WD_TMO_W  = 16;
    localparam int WD_CNT_W  = WD_TMO_W + 1;
    localparam int WD_DATA_W = 32;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_SVC   = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    typedef struct packed {
        logic [WD_TMO_W-1:0] tmo;
        logic                freeze;
        logic                enable;
        logic                rst_sel;
        logic                pre_on;
    } wd_ctrl_t;

    typedef enum logic {CTL_OPEN, CTL_SEALED} ctl_state_e;
    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
    typedef enum logic [1:0] {CNT_OFF, CNT_RUN, CNT_HALT} cnt_state_e;

    function automatic logic [WD_CNT_W-1:0] reload_of(input logic [WD_TMO_W-1:0] t);
        if (t == '0)
            reload_of = {1'b1, {WD_TMO_W{1'b0}}};
        else
            reload_of = {1'b0, t};
    endfunction
endpackage

// File: rtl/wdog_ctrl_lock.sv
`timescale 1ns/1ps
module wdog_ctrl_lock
    import wdog_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic [WD_TMO_W-1:0] tmo_in,
    input  logic [3:0]          flags_in,
    output wd_ctrl_t            ctrl_q,
    output wd_ctrl_t            ctrl_nxt,
    output logic                take
);
    ctl_state_e state, state_nxt;

    assign ctrl_nxt = '{tmo: tmo_in, freeze: flags_in[3], enable: flags_in[2],
                        rst_sel: flags_in[1], pre_on: flags_in[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CTL_OPEN;
        else        state <= state_nxt;
    end

    always_comb begin
        take      = 1'b0;
        state_nxt = state;
        unique case (state)
            CTL_OPEN: begin
                take      = wr_ctrl;
                state_nxt = wr_ctrl ? CTL_SEALED : CTL_OPEN;
            end
            CTL_SEALED: begin
                take      = 1'b0;
                state_nxt = CTL_SEALED;
            end
            default: begin
                take      = 1'b0;
                state_nxt = CTL_SEALED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctrl_q <= '0;
        else if (take) ctrl_q <= ctrl_nxt;
    end

    assert_sealed_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_SEALED) |=> $stable(ctrl_q));
    assert_sealed_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CTL_SEALED) |=> (state == CTL_SEALED));
endmodule

// File: rtl/wdog_key_seq.sv
`timescale 1ns/1ps
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_svc,
    input  logic [15:0] key,
    output logic        reload
);
    key_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KEY_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        reload    = 1'b0;
        state_nxt = state;
        unique case (state)
            KEY_IDLE: begin
                if (wr_svc && key == KEY_ARM) state_nxt = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (wr_svc) begin
                    reload    = (key == KEY_FIRE);
                    state_nxt = KEY_IDLE;
                end
            end
            default: state_nxt = KEY_IDLE;
        endcase
    end

    assert_fire_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (state == KEY_IDLE));
    assert_idle_no_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KEY_IDLE) |-> !reload);
endmodule

// File: rtl/wdog_down_ctr.sv
`timescale 1ns/1ps
module wdog_down_ctr
    import wdog_pkg::*;
#(
    parameter int PRESC_RATIO = 65536
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wd_ctrl_t            ctrl_q,
    input  wd_ctrl_t            ctrl_nxt,
    input  logic                load,
    input  logic                svc_reload,
    input  logic                dbg_halt,
    output logic [WD_CNT_W-1:0] count,
    output logic                exp_rst,
    output logic                exp_irq
);
    localparam int PRE_W = (PRESC_RATIO > 1) ? $clog2(PRESC_RATIO) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRESC_RATIO - 1);

    cnt_state_e       st, st_nxt;
    wd_ctrl_t         eff;
    logic             advance, tick, fire;
    logic [PRE_W-1:0] pre_q;

    assign eff = load ? ctrl_nxt : ctrl_q;

    always_comb begin
        if (!eff.enable)                 st_nxt = CNT_OFF;
        else if (eff.freeze && dbg_halt) st_nxt = CNT_HALT;
        else                             st_nxt = CNT_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CNT_OFF;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            CNT_OFF:  advance = 1'b0;
            CNT_RUN:  advance = 1'b1;
            CNT_HALT: advance = 1'b0;
            default:  advance = 1'b0;
        endcase
    end

    assign tick = advance && (!eff.pre_on || pre_q == PRE_MAX);
    assign fire = tick && !load && !svc_reload && (count == WD_CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre_q <= '0;
        else if (load || svc_reload)  pre_q <= '0;
        else if (advance && eff.pre_on)
            pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  count <= reload_of('0);
        else if (load || svc_reload) count <= reload_of(eff.tmo);
        else if (fire)               count <= reload_of(eff.tmo);
        else if (tick)               count <= count - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_rst <= 1'b0;
            exp_irq <= 1'b0;
        end else begin
            exp_rst <= fire && eff.rst_sel;
            exp_irq <= fire && !eff.rst_sel;
        end
    end

    assert_count_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) && (count <= reload_of('0)));
    assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_HALT && !load && !svc_reload) |=> $stable(count));
    assert_off_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CNT_OFF && !load && !svc_reload) |=> $stable(count));
    assert_expire_reloads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_rst || exp_irq) |-> (count == reload_of(ctrl_q.tmo)));
endmodule

// File: rtl/wdog_keyed.sv
`timescale 1ns/1ps
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int PRESC_RATIO = 65536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WD_DATA_W-1:0] reg_wdata,
    output logic [WD_DATA_W-1:0] reg_rdata,
    input  logic                 dbg_halt,
    output logic                 wdt_rst_req,
    output logic                 wdt_irq
);
    logic [1:0]          sel;
    logic                wr_ctrl, wr_svc, wr_stat;
    wd_ctrl_t            ctrl_q, ctrl_nxt;
    logic                take, svc_reload;
    logic [WD_CNT_W-1:0] count;
    logic                stat_q;

    assign sel     = reg_addr[1:0];
    assign wr_ctrl = reg_wr && sel == SEL_CTRL;
    assign wr_svc  = reg_wr && sel == SEL_SVC;
    assign wr_stat = reg_wr && sel == SEL_STAT;

    wdog_ctrl_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .tmo_in   (reg_wdata[31:16]),
        .flags_in (reg_wdata[3:0]),
        .ctrl_q   (ctrl_q),
        .ctrl_nxt (ctrl_nxt),
        .take     (take)
    );

    wdog_key_seq u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_svc (wr_svc),
        .key    (reg_wdata[15:0]),
        .reload (svc_reload)
    );

    wdog_down_ctr #(.PRESC_RATIO(PRESC_RATIO)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_q     (ctrl_q),
        .ctrl_nxt   (ctrl_nxt),
        .load       (take),
        .svc_reload (svc_reload),
        .dbg_halt   (dbg_halt),
        .count      (count),
        .exp_rst    (wdt_rst_req),
        .exp_irq    (wdt_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         stat_q <= 1'b0;
        else if (wdt_rst_req)               stat_q <= 1'b1;
        else if (wr_stat && reg_wdata[0])   stat_q <= 1'b0;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  reg_rdata = {ctrl_q.tmo, 12'h000, ctrl_q.freeze, ctrl_q.enable,
                                   ctrl_q.rst_sel, ctrl_q.pre_on};
            SEL_COUNT: reg_rdata = {{(WD_DATA_W-WD_CNT_W){1'b0}}, count};
            SEL_SVC:   reg_rdata = '0;
            SEL_STAT:  reg_rdata = {{(WD_DATA_W-1){1'b0}}, stat_q};
            default:   reg_rdata = '0;
        endcase
    end

    assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst_req && wdt_irq));
    assert_status_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> stat_q);
endmodule

// File: tb/wdog_keyed_tb.sv
`timescale 1ns/1ps
module wdog_keyed_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_halt = 1'b0;
    logic        wdt_rst_req, wdt_irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_SVC = 2'd2, A_STAT = 2'd3;

    // {first service word, second service word, reload expected}
    localparam logic [32:0] KEY_VEC [0:5] = '{
        {16'h556C, 16'hAA39, 1'b1},
        {16'hAA39, 16'hAA39, 1'b0},
        {16'h556C, 16'h556C, 1'b0},
        {16'h556C, 16'h1234, 1'b0},
        {16'h1234, 16'hAA39, 1'b0},
        {16'h556C, 16'hAA38, 1'b0}
    };

    always #5 clk = ~clk;

    wdog_keyed #(.PRESC_RATIO(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
        .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; dbg_halt = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c0;
        @(negedge clk);
        do_reset();

        // R1 reset state, R9 zero timeout value
        rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(A_CNT, v);  chk("R1 R9 count after reset", v, 32'h0001_0000);
        rd(A_STAT, v); chk("R1 status after reset", v, 32'h0);
        chk("R1 outputs after reset", {30'h0, wdt_rst_req, wdt_irq}, 32'h0);

        // Key table (R6): timeout 1000, enabled, interrupt mode
        wr(A_CTRL, 32'h03E8_0004);
        foreach (KEY_VEC[i]) begin
            wr(A_SVC, 32'h0000_0000);
            cycles(3);
            wr(A_SVC, {16'h0, KEY_VEC[i][32:17]});
            rd(A_CNT, c0);
            wr(A_SVC, {16'h0, KEY_VEC[i][16:1]});
            rd(A_CNT, v);
            chk($sformatf("R6 key row %0d", i), v, KEY_VEC[i][0] ? 32'd1000 : c0 - 1);
        end

        // R2 single-write lock
        do_reset();
        wr(A_CTRL, 32'hABCD_FFF6);
        rd(A_CTRL, v); chk("R2 first ctrl write latched", v, 32'hABCD_0006);
        rd(A_CNT, v);  chk("R4 count loaded on ctrl write", v, 32'h0000_ABCD);
        wr(A_CTRL, 32'h0001_0001);
        rd(A_CTRL, v); chk("R2 second ctrl write ignored", v, 32'hABCD_0006);

        // R3 disabled stays disabled
        do_reset();
        wr(A_CTRL, 32'h0005_0000);
        wr(A_CTRL, 32'h0005_0004);
        rd(A_CTRL, v); chk("R3 enable stays off", v, 32'h0005_0000);
        cycles(10);
        rd(A_CNT, v);  chk("R3 count frozen while disabled", v, 32'd5);
        chk("R3 no irq while disabled", {31'h0, wdt_irq}, 32'h0);

        // R4 R7 R8 interrupt-mode expiry, timeout 5
        do_reset();
        wr(A_CTRL, 32'h0005_0004);
        rd(A_CNT, v);  chk("R4 count after load", v, 32'd5);
        cycles(1);
        rd(A_CNT, v);  chk("R4 decrement per clock", v, 32'd4);
        cycles(3);
        rd(A_CNT, v);  chk("R4 count reaches 1", v, 32'd1);
        chk("R7 no irq before expiry", {31'h0, wdt_irq}, 32'h0);
        cycles(1);
        chk("R7 irq pulse", {30'h0, wdt_rst_req, wdt_irq}, 32'h1);
        rd(A_CNT, v);  chk("R8 reload on expiry", v, 32'd5);
        cycles(1);
        chk("R7 irq one cycle", {31'h0, wdt_irq}, 32'h0);
        rd(A_STAT, v); chk("R11 irq mode leaves status", v, 32'h0);

        // R7 R11 reset-mode expiry and sticky status
        do_reset();
        wr(A_CTRL, 32'h0005_0006);
        cycles(4);
        chk("R7 no reset request early", {31'h0, wdt_rst_req}, 32'h0);
        cycles(1);
        chk("R7 reset request pulse", {30'h0, wdt_rst_req, wdt_irq}, 32'h2);
        cycles(1);
        chk("R7 reset request one cycle", {31'h0, wdt_rst_req}, 32'h0);
        rd(A_STAT, v); chk("R11 status set", v, 32'h1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R11 write 0 keeps status", v, 32'h1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R11 write 1 clears status", v, 32'h0);

        // R5 prescale (bench uses ratio 16)
        do_reset();
        wr(A_CTRL, 32'h0003_0001 | 32'h4);
        cycles(15);
        rd(A_CNT, v);  chk("R5 held before ratio", v, 32'd3);
        cycles(1);
        rd(A_CNT, v);  chk("R5 decrement after ratio", v, 32'd2);
        cycles(32);
        chk("R5 expiry after 3 ratios", {31'h0, wdt_irq}, 32'h1);

        // R9 timeout field zero
        do_reset();
        wr(A_CTRL, 32'h0000_0006);
        rd(A_CNT, v);  chk("R9 zero timeout loads 65536", v, 32'h0001_0000);
        cycles(1);
        rd(A_CNT, v);  chk("R9 then 65535", v, 32'h0000_FFFF);

        // R10 freeze with debug halt
        do_reset();
        wr(A_CTRL, 32'h0064_000C);
        cycles(3);
        rd(A_CNT, v);  chk("R10 running before halt", v, 32'd97);
        dbg_halt = 1'b1;
        cycles(1);
        rd(A_CNT, v);  chk("R10 one clock latency", v, 32'd96);
        cycles(5);
        rd(A_CNT, v);  chk("R10 paused", v, 32'd96);
        dbg_halt = 1'b0;
        cycles(1);
        rd(A_CNT, v);  chk("R10 resume latency", v, 32'd96);
        cycles(1);
        rd(A_CNT, v);  chk("R10 resumed", v, 32'd95);

        do_reset();
        wr(A_CTRL, 32'h0064_0004);
        dbg_halt = 1'b1;
        cycles(3);
        rd(A_CNT, v);  chk("R10 halt ignored without freeze", v, 32'd97);
        dbg_halt = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule